// File: doc/BRIEF.md
# Backup Supply Selector and Reset Supervisor

This block is the digital control core of a memory backup supervisor. An analog front end reports three comparator flags: the main supply is above the trip point, the main supply is below the switch point, and the main supply is below the battery voltage. The block decides whether the memory rail is fed from the main supply or from the battery. It also generates an active-low system reset that covers both power-fail and power-on, and it keeps a freshness seal. While the seal is set the battery is never used. This lets a cell be fitted at assembly and kept unused until the first real power-up.

All three flags cross into the clock domain through two-flop synchronizers. The seal is set out of reset and is cleared when the synchronized supply-good flag first rises. Software can set the seal again with an explicit command, but only while the supply is good. The reset output follows supply-good low at once. It is released only after a parameterized number of consecutive good cycles, which is the power-on hold. A tolerance-select configuration bit is registered and passed on to the comparator stage, where it picks the trip window.

Top module: `bkup_supervisor`

## Requirements
- R1: `batt_sel` is 1 exactly when the synchronized below-switch flag and the synchronized below-battery flag are both 1 and the seal is clear.
- R2: While the seal is set, `backup_en` is 0 and `batt_sel` is 0, whatever the comparator flags are.
- R3: While `rst_n` is low and directly after it is released, the seal is set (`backup_en` = 0), `batt_sel` = 0, `rst_out_n` = 0 and `trip_tol10` = 0.
- R4: When the synchronized supply-good flag goes from 0 to 1, the seal clears on the next clock edge and `backup_en` becomes 1. This only happens if no seal command is applied on that edge.
- R5: `seal_cmd` = 1 sampled on an edge sets the seal if the synchronized supply-good flag is 1 at that edge. If that flag is 0, the command is ignored and `backup_en` keeps its value.
- R6: `rst_out_n` is 0 in every cycle in which the synchronized supply-good flag is 0.
- R7: `rst_out_n` becomes 1 only after the synchronized supply-good flag has been 1 at HOLD_CYCLES consecutive clock edges. Any cycle in which the flag is 0 restarts the count from zero.
- R8: A change on `supply_ok`, `below_switch` or `below_batt` reaches the decision logic through two flops. It first affects the outputs after the second rising edge that samples it.
- R9: `trip_tol10` equals the value of `tol10_sel` sampled at the previous rising edge (1 selects the 10 % window, 0 the 5 % window).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| supply_ok | input | 1 | Comparator: main supply above trip point (asynchronous) |
| below_switch | input | 1 | Comparator: main supply below switch point (asynchronous) |
| below_batt | input | 1 | Comparator: main supply below battery voltage (asynchronous) |
| tol10_sel | input | 1 | Tolerance selection, 1 = 10 % window, 0 = 5 % window |
| seal_cmd | input | 1 | Request to re-enter the freshness seal (honoured only while supply is good) |
| batt_sel | output | 1 | 1 = memory rail fed from battery |
| backup_en | output | 1 | 1 = battery backup allowed (seal clear) |
| rst_out_n | output | 1 | Active-low system reset |
| trip_tol10 | output | 1 | Registered tolerance selection to comparator stage |

## Verification
The embedded properties check on every cycle that the battery path stays off while sealed and that reset is low whenever synchronized supply is low. They also check that the seal is set only by a command taken with good supply, that a rising good flag clears it, and that the hold counter never passes its limit. Other behaviours need the bench's scenarios: the exact release cycle of reset after the hold, the restart of the hold after a one-cycle dip, the two-edge synchronizer latency, and an ignored seal command while supply is low. The bench's reference model is compared against all four outputs on every cycle through those scenarios.

// File: rtl/bkup_pkg.sv
package bkup_pkg;
  localparam int unsigned NUM_FLAGS = 3;
  localparam int unsigned SYNC_STAGES = 2;

  typedef struct packed {
    logic ok;     // supply above trip point
    logic bsw;    // supply below switch point
    logic bbat;   // supply below battery voltage
  } comp_flags_t;
endpackage

// File: rtl/bkup_flag_sync.sv
module bkup_flag_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  localparam int unsigned LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], async_in[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_d;
    end

    assign sync_out[b] = chain_q[LAST];
  end
endmodule

// File: rtl/bkup_seal_ctrl.sv
module bkup_seal_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ok_s,
  input  logic seal_cmd,
  output logic sealed
);
  logic sealed_q, sealed_d;
  logic ok_prev_q;
  logic ok_rise;

  assign ok_rise = ok_s & ~ok_prev_q;

  always_comb begin
    sealed_d = sealed_q;
    if (seal_cmd && ok_s) sealed_d = 1'b1;
    else if (ok_rise)     sealed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sealed_q  <= 1'b1;
      ok_prev_q <= 1'b0;
    end else begin
      sealed_q  <= sealed_d;
      ok_prev_q <= ok_s;
    end
  end

  assign sealed = sealed_q;

  // R4: a first rise of good supply unseals unless a command competes
  assert_seal_clear_on_rise_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    (sealed_q && ok_s && !ok_prev_q && !seal_cmd) |=> !sealed_q);

  // R5: seal is only ever re-entered by a command taken with good supply
  assert_seal_only_by_cmd_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (!sealed_q && !(seal_cmd && ok_s)) |=> !sealed_q);
endmodule

// File: rtl/bkup_reset_hold.sv
module bkup_reset_hold #(
  parameter int unsigned HOLD_CYCLES = 6554
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ok_s,
  output logic rst_out_n
);
  localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          at_hold;

  assign at_hold = (cnt_q == HOLD_V);
  assign cnt_en  = ok_s & ~at_hold;

  always_comb begin
    cnt_d = cnt_q;
    if (!ok_s)       cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign rst_out_n = ok_s & at_hold;

  // R7: counter never runs past the hold limit
  assert_cnt_bound_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= HOLD_V);

  // R7: a dip always clears the count
  assert_dip_restart_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    !ok_s |=> (cnt_q == '0));

  // R7: release only follows a good cycle
  assert_release_after_good_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> $past(ok_s));
endmodule

// File: rtl/bkup_supervisor.sv
module bkup_supervisor #(
  parameter int unsigned HOLD_CYCLES = 6554
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic below_switch,
  input  logic below_batt,
  input  logic tol10_sel,
  input  logic seal_cmd,
  output logic batt_sel,
  output logic backup_en,
  output logic rst_out_n,
  output logic trip_tol10
);
  import bkup_pkg::*;

  comp_flags_t raw_flags, syn_flags;
  logic        sealed;
  logic        tol_q;

  assign raw_flags = '{ok: supply_ok, bsw: below_switch, bbat: below_batt};

  bkup_flag_sync #(
    .WIDTH (NUM_FLAGS),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(raw_flags),
    .sync_out(syn_flags)
  );

  bkup_seal_ctrl u_seal (
    .clk     (clk),
    .rst_n   (rst_n),
    .ok_s    (syn_flags.ok),
    .seal_cmd(seal_cmd),
    .sealed  (sealed)
  );

  bkup_reset_hold #(
    .HOLD_CYCLES(HOLD_CYCLES)
  ) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .ok_s     (syn_flags.ok),
    .rst_out_n(rst_out_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tol_q <= 1'b0;
    else        tol_q <= tol10_sel;
  end

  assign trip_tol10 = tol_q;
  assign backup_en  = ~sealed;
  assign batt_sel   = syn_flags.bsw & syn_flags.bbat & ~sealed;

  // R2: battery path never active while sealed
  assert_no_batt_sealed_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    batt_sel |-> backup_en);

  // R6: reset output low whenever synchronized supply is low
  assert_rst_on_fail_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    !syn_flags.ok |-> !rst_out_n);

  // R9: tolerance selection forwarded one edge later
  assert_tol_forward_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (trip_tol10 == $past(tol10_sel)));
endmodule

// File: tb/bkup_supervisor_bench.sv
module bkup_supervisor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0, below_switch = 1'b0, below_batt = 1'b0;
  logic tol10_sel = 1'b0, seal_cmd = 1'b0;
  logic batt_sel, backup_en, rst_out_n, trip_tol10;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bkup_supervisor #(.HOLD_CYCLES(HOLD)) u_bkup_supervisor (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .below_switch(below_switch),
    .below_batt(below_batt), .tol10_sel(tol10_sel), .seal_cmd(seal_cmd),
    .batt_sel(batt_sel), .backup_en(backup_en), .rst_out_n(rst_out_n),
    .trip_tol10(trip_tol10)
  );

  // Behavioural reference: sample histories, seal flag, good-run length
  bit hq_ok[$], hq_bsw[$], hq_bbat[$];
  bit m_sealed;
  int m_run;
  bit m_tol;

  task automatic model_clear();
    hq_ok = {0, 0, 0}; hq_bsw = {0, 0, 0}; hq_bbat = {0, 0, 0};
    m_sealed = 1; m_run = 0; m_tol = 0;
  endtask

  initial model_clear();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_clear();
    else begin
      bit pre_ok, pre_okq;
      pre_ok  = hq_ok[1];
      pre_okq = hq_ok[2];
      if (seal_cmd && pre_ok)  m_sealed = 1;
      else if (pre_ok && !pre_okq) m_sealed = 0;
      m_run = pre_ok ? m_run + 1 : 0;
      m_tol = tol10_sel;
      hq_ok.push_front(supply_ok);     void'(hq_ok.pop_back());
      hq_bsw.push_front(below_switch); void'(hq_bsw.pop_back());
      hq_bbat.push_front(below_batt);  void'(hq_bbat.pop_back());
    end
  end

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      bit e_batt, e_bk, e_rst;
      e_bk   = !m_sealed;
      e_batt = hq_bsw[1] && hq_bbat[1] && !m_sealed;
      e_rst  = hq_ok[1] && (m_run >= HOLD);
      check("R1 batt_sel", batt_sel, e_batt);
      check("R2 backup_en", backup_en, e_bk);
      check("R7 rst_out_n", rst_out_n, e_rst);
      check("R9 trip_tol10", trip_tol10, m_tol);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    step(3);
    // R3: state during reset
    check("R3 backup_en in reset", backup_en, 1'b0);
    check("R3 rst_out_n in reset", rst_out_n, 1'b0);
    check("R3 batt_sel in reset", batt_sel, 1'b0);
    rst_n = 1'b1;
    step(1);
    check("R3 backup_en after release", backup_en, 1'b0);
    check("R3 trip_tol10 after release", trip_tol10, 1'b0);

    // R2: sealed with backup conditions present, battery not used
    below_switch = 1; below_batt = 1;
    step(5);
    check("R2 sealed batt_sel", batt_sel, 1'b0);

    // R4, R8: supply comes up; seal clears after sync plus one edge
    below_switch = 0; below_batt = 0; supply_ok = 1; tol10_sel = 1;
    step(1);
    check("R8 one edge no effect", backup_en, 1'b0);
    check("R9 tol forwarded", trip_tol10, 1'b1);
    step(2);
    check("R4 seal cleared", backup_en, 1'b1);

    // R7: hold then dip restarts count
    step(HOLD - 6);
    supply_ok = 0;
    step(1);
    supply_ok = 1;
    step(3);
    check("R6 reset during dip", rst_out_n, 1'b0);
    step(HOLD + 3);
    check("R7 released after hold", rst_out_n, 1'b1);

    // R6, R1: power fail, battery conditions
    supply_ok = 0; below_switch = 1; below_batt = 0;
    step(2);
    check("R6 reset on fail", rst_out_n, 1'b0);
    check("R1 only switch flag", batt_sel, 1'b0);
    below_batt = 1;
    step(1);
    check("R8 one edge latency", batt_sel, 1'b0);
    step(1);
    check("R1 both flags", batt_sel, 1'b1);
    below_switch = 0;
    step(2);
    check("R1 only battery flag", batt_sel, 1'b0);

    // R5: seal command with supply low ignored
    below_switch = 1;
    seal_cmd = 1;
    step(2);
    seal_cmd = 0;
    check("R5 ignored backup_en", backup_en, 1'b1);
    check("R5 ignored batt_sel", batt_sel, 1'b1);

    // R5: command with supply good seals; the rise clears first, then re-seal
    supply_ok = 1; below_switch = 0; below_batt = 0;
    step(HOLD + 4);
    seal_cmd = 1;
    step(1);
    seal_cmd = 0;
    check("R5 sealed by cmd", backup_en, 1'b0);
    tol10_sel = 0;
    supply_ok = 0; below_switch = 1; below_batt = 1;
    step(4);
    check("R2 resealed batt_sel", batt_sel, 1'b0);

    // R4: next power-up unseals again
    supply_ok = 1; below_switch = 0; below_batt = 0;
    step(4);
    check("R4 unseal again", backup_en, 1'b1);
    step(HOLD + 3);

    // R3: async reset mid-operation
    rst_n = 0;
    #1;
    check("R3 async reset rst_out_n", rst_out_n, 1'b0);
    check("R3 async reset backup_en", backup_en, 1'b0);
    step(2);
    rst_n = 1;
    step(HOLD + 6);
    check("R7 released after reset", rst_out_n, 1'b1);
    finish_run();
  end
endmodule